// File: doc/BRIEF.md
# Dual-Port RAM with Address Stall

This block is a synchronous memory with one write port and one read port. The write side registers a data word, a word address, a write strobe and a per-byte lane mask. The stored word is updated one clock edge later, and only in the lanes whose mask bit is set. The read side registers a word address and a read strobe. The addressed word is then loaded into an output register on the following edge of the output clock.

Each address register has its own stall input. While a stall input is high, its address register keeps the address it last captured, so a stream of accesses can be pinned to one location without the upstream logic having to hold the address lines. A build-time parameter selects one of three ways of assigning the two clock inputs to the registers. Each clock input has its own clock enable.

Top module: `dp_stall_ram`

## Requirements
- R1: `wr_be` bit i controls data bits [8i+7:8i]. A write replaces only the lanes whose mask bit is 1, and every other lane keeps its stored value. A mask of all zeros leaves the word unchanged.
- R2: While `wr_addr_stall` is high on a capturing edge, the write address register keeps its previous value and `wr_addr` is ignored. A write issued in that cycle lands at the held address.
- R3: While `rd_addr_stall` is high on a capturing edge, the read address register keeps its previous value and `rd_addr` is ignored. A read issued in that cycle returns the word at the held address.
- R4: A write is stored on the input-clock edge after it is captured. A read address captured on one edge appears on `rd_data` at the next enabled output-register edge, provided the registered read strobe is 1. `rd_data` has the same width as `wr_data`.
- R5: When a read and a write to the same address are captured on the same edge in single-clock mode, the read returns the word as it was before that write.
- R6: `MODE` sets which clock drives each register. With 0 (single), every register uses `in_clk`. With 1 (write/read), the write-side registers and the storage use `in_clk`, while the read address, the read strobe and `rd_data` use `out_clk`. With 2 (input/output), every input register uses `in_clk` and only `rd_data` uses `out_clk`.
- R7: `in_ce` enables the registers and storage writes clocked by the write-side domain. `out_ce` enables the `rd_data` register, and also the read input registers in mode 1. When an enable is low, every register it governs holds its value.
- R8: While the registered read strobe is 0, `rd_data` holds its last value, whatever `rd_addr` does.
- R9: While `rst_n` is low, `rd_data` reads 0 and both registered strobes are cleared. Stored words are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input-side clock; the only clock in mode 0 |
| out_clk | input | 1 | Output-side clock (modes 1 and 2) |
| in_ce | input | 1 | Clock enable for the input-side registers and storage |
| out_ce | input | 1 | Clock enable for the output register (and the read inputs in mode 1) |
| rst_n | input | 1 | Asynchronous active-low reset of the port registers |
| wr_data | input | DW | Write data word |
| wr_addr | input | AW | Write word address |
| wr_en | input | 1 | Write strobe |
| wr_be | input | DW/8 | Byte lane mask for the write |
| wr_addr_stall | input | 1 | Holds the write address register |
| rd_addr | input | AW | Read word address |
| rd_en | input | 1 | Read strobe |
| rd_addr_stall | input | 1 | Holds the read address register |
| rd_data | output | DW | Registered read data |

## Verification
On every cycle, the assertions check that a stalled address register keeps its value and that a disabled clock domain freezes its port registers. They also check that the output register holds whenever the read strobe or its enable is low. Several behaviours can only be shown by the bench's scenarios, run against a reference array on all three clock modes at once with unrelated clock periods: lane masking, the landing address of a stalled write, read-before-write ordering, and the data that finally appears after crossing between the two clocks.

// File: rtl/dpsr_pkg.sv
package dpsr_pkg;

  // Assignment of the two clock inputs to the port registers
  typedef enum logic [1:0] {
    CLK_SINGLE = 2'd0,  // everything on in_clk
    CLK_WRRD   = 2'd1,  // write side on in_clk, read side on out_clk
    CLK_INOUT  = 2'd2   // all inputs on in_clk, output register on out_clk
  } clk_mode_e;

endpackage

// File: rtl/dpsr_wr_port.sv
module dpsr_wr_port #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          stall,
  input  logic          en,
  input  logic [DW-1:0] data,
  input  logic [BW-1:0] be,
  output logic [AW-1:0] addr_q,
  output logic          en_q,
  output logic [DW-1:0] data_q,
  output logic [BW-1:0] be_q
);

  // named event: the address register follows its input this edge
  logic addr_take;
  assign addr_take = ce & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
      data_q <= '0;
      be_q   <= '0;
    end else if (ce) begin
      if (addr_take) addr_q <= addr;
      en_q   <= en;
      data_q <= data;
      be_q   <= be;
    end
  end

  // R2
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && stall) |=> $stable(addr_q));

  // R7
  wr_ce_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(addr_q) && $stable(en_q) && $stable(data_q) && $stable(be_q)));

endmodule

// File: rtl/dpsr_rd_port.sv
module dpsr_rd_port #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          stall,
  input  logic          en,
  output logic [AW-1:0] addr_q,
  output logic          en_q
);

  logic addr_take;
  assign addr_take = ce & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      en_q   <= 1'b0;
    end else if (ce) begin
      if (addr_take) addr_q <= addr;
      en_q <= en;
    end
  end

  // R3
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && stall) |=> $stable(addr_q));

  // R7
  rd_ce_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(addr_q) && $stable(en_q)));

endmodule

// File: rtl/dpsr_store.sv
module dpsr_store #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int BW = DW / 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk,
  input  logic          wce,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] wbe,
  input  logic          oclk,
  input  logic          oce,
  input  logic          rst_n,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  // lane-by-lane choice between the stored word and the new word
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [BW-1:0] sel);
    logic [DW-1:0] res;
    res = old_w;
    for (int i = 0; i < BW; i++) begin
      if (sel[i]) res[8*i +: 8] = new_w[8*i +: 8];
    end
    return res;
  endfunction

  logic wr_fire;
  logic rd_fire;
  assign wr_fire = wce & wen;
  assign rd_fire = oce & ren;

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= lane_merge(mem[waddr], wdata, wbe);
  end

  // nonblocking update of mem gives read-before-write on a shared edge
  always_ff @(posedge oclk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (rd_fire) q <= mem[raddr];
  end

  // R8
  q_hold_chk: assert property (@(posedge oclk) disable iff (!rst_n)
    (!oce || !ren) |=> $stable(q));

endmodule

// File: rtl/dp_stall_ram.sv
module dp_stall_ram #(
  parameter int                  AW   = 8,
  parameter int                  DW   = 32,
  parameter dpsr_pkg::clk_mode_e MODE = dpsr_pkg::CLK_SINGLE
) (
  input  logic              in_clk,
  input  logic              out_clk,
  input  logic              in_ce,
  input  logic              out_ce,
  input  logic              rst_n,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     wr_addr,
  input  logic              wr_en,
  input  logic [DW/8-1:0]   wr_be,
  input  logic              wr_addr_stall,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_en,
  input  logic              rd_addr_stall,
  output logic [DW-1:0]     rd_data
);

  localparam int BW = DW / 8;
  localparam bit RD_ON_OUT = (MODE == dpsr_pkg::CLK_WRRD);
  localparam bit Q_ON_OUT  = (MODE != dpsr_pkg::CLK_SINGLE);

  // clock and enable chosen for the read input registers and the output register
  logic rin_clk, rin_ce, q_clk;
  assign rin_clk = RD_ON_OUT ? out_clk : in_clk;
  assign rin_ce  = RD_ON_OUT ? out_ce  : in_ce;
  assign q_clk   = Q_ON_OUT  ? out_clk : in_clk;

  logic [AW-1:0] waddr_q, raddr_q;
  logic [DW-1:0] wdata_q;
  logic [BW-1:0] wbe_q;
  logic          wen_q, ren_q;

  dpsr_wr_port #(.AW(AW), .DW(DW), .BW(BW)) u_wr (
    .clk(in_clk), .ce(in_ce), .rst_n(rst_n),
    .addr(wr_addr), .stall(wr_addr_stall), .en(wr_en),
    .data(wr_data), .be(wr_be),
    .addr_q(waddr_q), .en_q(wen_q), .data_q(wdata_q), .be_q(wbe_q)
  );

  dpsr_rd_port #(.AW(AW)) u_rd (
    .clk(rin_clk), .ce(rin_ce), .rst_n(rst_n),
    .addr(rd_addr), .stall(rd_addr_stall), .en(rd_en),
    .addr_q(raddr_q), .en_q(ren_q)
  );

  dpsr_store #(.AW(AW), .DW(DW), .BW(BW)) u_mem (
    .wclk(in_clk), .wce(in_ce), .wen(wen_q), .waddr(waddr_q),
    .wdata(wdata_q), .wbe(wbe_q),
    .oclk(q_clk), .oce(out_ce), .rst_n(rst_n),
    .ren(ren_q), .raddr(raddr_q), .q(rd_data)
  );

endmodule

// File: tb/dp_stall_ram_tb.sv
`timescale 1ns/100ps
module dp_stall_ram_tb;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int BW = DW / 8;
  localparam int NW = 1 << AW;

  logic in_clk, out_clk;
  logic in_ce, out_ce, rst_n;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [BW-1:0] wr_be;
  logic wr_en, wr_addr_stall, rd_en, rd_addr_stall;
  logic [DW-1:0] q_m [3];

  logic [DW-1:0] ref_mem [NW];
  int n_cmp = 0;
  int n_bad = 0;

  // 250 MHz input clock; output clock 7 ns, its rising edges on half-ns marks
  initial begin in_clk = 1'b0; forever #2 in_clk = ~in_clk; end
  initial begin out_clk = 1'b0; #0.5; forever begin out_clk = ~out_clk; #3.5; end end

  for (genvar m = 0; m < 3; m++) begin : g_mode
    dp_stall_ram #(.AW(AW), .DW(DW), .MODE(dpsr_pkg::clk_mode_e'(m))) u_dut (
      .in_clk(in_clk), .out_clk(out_clk), .in_ce(in_ce), .out_ce(out_ce),
      .rst_n(rst_n), .wr_data(wr_data), .wr_addr(wr_addr), .wr_en(wr_en),
      .wr_be(wr_be), .wr_addr_stall(wr_addr_stall), .rd_addr(rd_addr),
      .rd_en(rd_en), .rd_addr_stall(rd_addr_stall), .rd_data(q_m[m])
    );
  end

  // expected word after a masked write, built from a bit mask
  function automatic logic [DW-1:0] exp_merge(input logic [DW-1:0] old_w,
                                              input logic [DW-1:0] new_w,
                                              input logic [BW-1:0] sel);
    logic [DW-1:0] msk = '0;
    for (int b = 0; b < BW; b++) msk = msk | ({{(DW-8){1'b0}}, {8{sel[b]}}} << (8 * b));
    return (old_w & ~msk) | (new_w & msk);
  endfunction

  task automatic check(input int m, input string req, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s mode%0d got %h expected %h", req, m, got, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [DW-1:0] exp);
    for (int m = 0; m < 3; m++) check(m, req, q_m[m], exp);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [BW-1:0] be, input bit upd);
    @(negedge in_clk);
    wr_addr = a; wr_data = d; wr_be = be; wr_en = 1'b1;
    @(negedge in_clk);
    wr_en = 1'b0;
    @(negedge in_clk);
    if (upd) ref_mem[a] = exp_merge(ref_mem[a], d, be);
  endtask

  // read strobe held long enough to be seen by either clock, then settle
  task automatic do_read(input logic [AW-1:0] a);
    @(negedge in_clk);
    rd_addr = a; rd_en = 1'b1;
    repeat (5) @(negedge in_clk);
    rd_en = 1'b0;
    repeat (3) @(negedge in_clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] old_w;
    rst_n = 1'b0; in_ce = 1'b1; out_ce = 1'b1;
    wr_data = '0; wr_addr = '0; wr_en = 1'b0; wr_be = '0; wr_addr_stall = 1'b0;
    rd_addr = '0; rd_en = 1'b0; rd_addr_stall = 1'b0;
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    repeat (3) @(negedge in_clk);
    check_all("R9 reset output", '0);
    rst_n = 1'b1;
    repeat (2) @(negedge in_clk);

    // fill with distinct words, then masked writes with random lanes
    for (int a = 0; a < NW; a++) do_write(AW'(a), DW'(a * 16'h1357) ^ 16'hA5C3, '1, 1'b1);
    for (int k = 0; k < 48; k++)
      do_write(AW'($urandom % NW), DW'($urandom), BW'($urandom % 4), 1'b1);
    for (int a = 0; a < NW; a++) begin
      do_read(AW'(a));
      check_all("R1 R4 R6 sweep", ref_mem[a]);
    end

    // write address stall: the write lands at the held address
    do_write(4'd3, 16'h3C3C, 2'b11, 1'b1);
    @(negedge in_clk);
    wr_addr = 4'd9; wr_addr_stall = 1'b1; wr_data = 16'hBEEF; wr_be = 2'b01; wr_en = 1'b1;
    @(negedge in_clk);
    wr_en = 1'b0; wr_addr_stall = 1'b0;
    @(negedge in_clk);
    ref_mem[3] = exp_merge(ref_mem[3], 16'hBEEF, 2'b01);
    do_read(4'd3); check_all("R2 held address written", ref_mem[3]);
    do_read(4'd9); check_all("R2 new address untouched", ref_mem[9]);

    // read address stall: the read returns the held address
    do_read(4'd3);
    @(negedge in_clk);
    rd_addr = 4'd9; rd_addr_stall = 1'b1; rd_en = 1'b1;
    repeat (5) @(negedge in_clk);
    rd_en = 1'b0;
    repeat (3) @(negedge in_clk);
    check_all("R3 held read address", ref_mem[3]);
    rd_addr_stall = 1'b0;

    // read strobe low: output holds while the address moves
    do_read(4'd9);
    @(negedge in_clk);
    rd_addr = 4'd3;
    repeat (8) @(negedge in_clk);
    check_all("R8 hold without strobe", ref_mem[9]);

    // input enable low blocks a write
    do_write(4'd5, 16'h1111, 2'b11, 1'b1);
    do_write(4'd6, 16'h2222, 2'b11, 1'b1);
    @(negedge in_clk); in_ce = 1'b0;
    do_write(4'd5, 16'hDEAD, 2'b11, 1'b0);
    @(negedge in_clk); in_ce = 1'b1;
    do_read(4'd5); check_all("R7 in_ce low no write", ref_mem[5]);

    // output enable low freezes the output register
    @(negedge in_clk); out_ce = 1'b0;
    do_read(4'd6); check_all("R7 out_ce low output held", ref_mem[5]);
    @(negedge in_clk); out_ce = 1'b1;
    do_read(4'd6); check_all("R7 R4 after out_ce restored", ref_mem[6]);

    // same-edge read and write to one address, single-clock mode
    old_w = ref_mem[7];
    @(negedge in_clk);
    wr_addr = 4'd7; wr_data = 16'h7E57; wr_be = 2'b11; wr_en = 1'b1;
    rd_addr = 4'd7; rd_en = 1'b1;
    @(negedge in_clk);
    wr_en = 1'b0; rd_en = 1'b0;
    @(negedge in_clk);
    check(0, "R5 read-before-write", q_m[0], old_w);
    ref_mem[7] = 16'h7E57;
    repeat (3) @(negedge in_clk);
    do_read(4'd7); check_all("R5 new data after", ref_mem[7]);

    for (int a = 0; a < NW; a++) begin
      do_read(AW'(a));
      check_all("R1 R6 final sweep", ref_mem[a]);
    end

    summary();
    $finish;
  end

endmodule